// File: doc/BRIEF.md
# FM Direct Digital Synthesiser

This block synthesises a frequency-modulated carrier for an external 8-bit R-2R resistor ladder. A 32-bit phase register advances on every system clock. The step is a carrier tuning word plus a deviation term, formed from a signed 16-bit modulation sample and an unsigned 24-bit deviation gain. The top ten phase bits address a quarter-wave sine table. The table value is turned into an offset-binary 8-bit code.

The modulation sample comes from one of two sources. The first is an external sample stream. The second is a built-in test-tone oscillator: a second phase register that reads the same sine table. At a 60 MHz clock the default tone step gives about 1 kHz. A tuning word of 0x2DA740DA gives a 10.7 MHz carrier. A gain near 172166 gives 2405 Hz peak deviation with the full-scale tone, which is the carrier's first null. A gain near 5.37e6 gives 75 kHz.

Configuration writes land in holding registers. They take effect only on a sample strobe, so the phase step never changes partway between samples.

Top module: `fm_dds`

## Requirements
- R1: While `rst_n` is low and in the first cycle after release, `dac_code` is 0x80. All phase, holding, active and sample registers reset to zero.
- R2: `dac_code` after clock edge n+1 equals (s >>> 8) + 128, where s is the signed sine of phase bits [31:22] held after edge n. The sine is built from a quarter table m[i] = round(32767*sin((i+0.5)*pi/512)), i = 0..255. For index p: i = p[7:0], or 255 - p[7:0] when p[8] is set; s = m[i], negated when p[9] is set. Phase 0 therefore gives 128.
- R3: On every clock the phase gains the active carrier word plus the deviation term, modulo 2^32.
- R4: The deviation term is floor(sample * gain / 2^15). It uses the held signed sample and the active unsigned gain, and is sign-extended to 32 bits, so negative samples lower the frequency.
- R5: A write with `cfg_we` high targets a holding register by `cfg_sel`: 0 is the carrier word (32 bits), 1 is the gain (data bits 23:0), 2 is the source select (bit 0, 1 = test tone). Holding values copy to the active carrier and gain only on an edge where `smp_stb` is high. A write in the same cycle as a strobe waits for the next strobe.
- R6: On a strobe edge the modulation sample is latched from the selected source and then held until the next strobe. The selection used is the holding value before any write on that same edge: 0 selects `smp_in`, 1 selects the test tone.
- R7: The test-tone phase advances by TONE_FTW (default 71583) on every clock. Its sample is the signed 16-bit sine of its top ten bits, using the same table as R2.
- R8: Writes with `cfg_sel` = 3 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (nominally 60 MHz) |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_sel | input | 2 | Holding register select |
| cfg_data | input | 32 | Configuration write data |
| smp_stb | input | 1 | Sample strobe: commits configuration and latches the sample |
| smp_in | input | 16 | External signed modulation sample |
| dac_code | output | 8 | Offset-binary code for the R-2R DAC |

## Verification
A carrier or gain write that is paired with a strobe alters the phase step on the edge after that strobe. It reaches `dac_code` one edge later still. A new sample takes the same two edges, and a plain phase change shows one edge after it happens. The bench keeps a cycle-exact model of the holding, active, sample and both phase registers, and advances it right after each rising edge using the inputs it drove at the preceding falling edge. It compares `dac_code` with the model on every falling edge, so every latency is checked exactly, including writes that are held back until the next strobe.

// File: rtl/fm_dds.sv
module fm_dds #(
  parameter int PW = 32,
  parameter int AW = 10,
  parameter int SW = 16,
  parameter int GW = 24,
  parameter int DW = 8,
  parameter logic [PW-1:0] TONE_FTW = 71583
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_sel,
  input  logic [PW-1:0] cfg_data,
  input  logic          smp_stb,
  input  logic [SW-1:0] smp_in,
  output logic [DW-1:0] dac_code
);
  localparam int QN   = 1 << (AW - 2);
  localparam int PRW  = SW + GW + 1;
  localparam int DEVW = PRW - (SW - 1);
  localparam real AMP = 2.0 ** (SW - 1) - 1.0;
  localparam real PI  = 3.14159265358979;

  logic [SW-2:0] qtab [QN];
  initial
    for (int i = 0; i < QN; i++)
      qtab[i] = (SW-1)'($rtoi(AMP * $sin((i + 0.5) * PI / (2.0 * QN)) + 0.5));

  function automatic logic signed [SW-1:0] sin_of(input logic [AW-1:0] p);
    logic [AW-3:0] idx;
    logic signed [SW-1:0] m;
    idx = p[AW-2] ? ~p[AW-3:0] : p[AW-3:0];
    m = $signed({1'b0, qtab[idx]});
    return p[AW-1] ? -m : m;
  endfunction

  logic [PW-1:0] sh_ftw, act_ftw, phase, tone_ph;
  logic [GW-1:0] sh_gain, act_gain;
  logic          sh_src;
  logic signed [SW-1:0] mod_reg, wave, tone_s;
  logic signed [PRW-1:0] prod;
  logic signed [DEVW-1:0] dev;

  assign prod   = mod_reg * $signed({1'b0, act_gain});
  assign dev    = prod[PRW-1:SW-1];
  assign wave   = sin_of(phase[PW-1 -: AW]);
  assign tone_s = sin_of(tone_ph[PW-1 -: AW]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_ftw   <= '0;
      sh_gain  <= '0;
      sh_src   <= 1'b0;
      act_ftw  <= '0;
      act_gain <= '0;
      mod_reg  <= '0;
      phase    <= '0;
      tone_ph  <= '0;
      dac_code <= {1'b1, {(DW-1){1'b0}}};
    end else begin
      phase    <= phase + act_ftw + PW'(dev);
      tone_ph  <= tone_ph + TONE_FTW;
      dac_code <= {~wave[SW-1], wave[SW-2 -: DW-1]};
      if (smp_stb) begin
        act_ftw  <= sh_ftw;
        act_gain <= sh_gain;
        mod_reg  <= sh_src ? tone_s : $signed(smp_in);
      end
      if (cfg_we)
        case (cfg_sel)
          2'd0: sh_ftw  <= cfg_data;
          2'd1: sh_gain <= cfg_data[GW-1:0];
          2'd2: sh_src  <= cfg_data[0];
          default: ;
        endcase
    end
  end

  // R5: active carrier and gain move only on a strobe
  a_r5_commit_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_stb |=> ($stable(act_ftw) && $stable(act_gain)));
  // R6: the modulation sample holds between strobes
  a_r6_sample_held: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_stb |=> $stable(mod_reg));
  // R2: zero phase index yields mid-scale code
  a_r2_zero_mid: assert property (@(posedge clk) disable iff (!rst_n)
    (phase[PW-1 -: AW] == '0) |=> (dac_code == {1'b1, {(DW-1){1'b0}}}));
  // R2: second half of the cycle lies below mid-scale
  a_r2_neg_half: assert property (@(posedge clk) disable iff (!rst_n)
    phase[PW-1] |=> !dac_code[DW-1]);
  // R3: no step means the phase holds
  a_r3_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (act_ftw == '0 && (act_gain == '0 || mod_reg == '0)) |=> $stable(phase));
endmodule

// File: tb/sim_fm_dds.sv
module sim_fm_dds;
  localparam int CLK_NS = 16;
  localparam int TONE = 71583;

  logic clk = 0, rst_n = 0, cfg_we = 0, smp_stb = 0;
  logic [1:0] cfg_sel = 0;
  logic [31:0] cfg_data = 0;
  logic [15:0] smp_in = 0;
  logic [7:0] dac_code;
  int total = 0, bad = 0;
  string req = "R1";

  fm_dds u0 (.clk, .rst_n, .cfg_we, .cfg_sel, .cfg_data, .smp_stb, .smp_in, .dac_code);

  always #(CLK_NS/2) clk = ~clk;

  bit [31:0] m_shf, m_ftw, m_ph, m_tph;
  bit [23:0] m_shg, m_gain;
  bit m_src;
  int m_mod;
  bit [7:0] m_dac;

  function automatic int sine16(bit [31:0] ph);
    int p, i, m;
    p = int'(ph >> 22);
    i = p & 255;
    if (p & 256) i = 255 - i;
    m = $rtoi(32767.0 * $sin((i + 0.5) * 3.14159265358979 / 512.0) + 0.5);
    return (p & 512) ? -m : m;
  endfunction

  function automatic bit [7:0] dac_of(bit [31:0] ph);
    int s;
    s = sine16(ph);
    return 8'((s >>> 8) + 128);
  endfunction

  task automatic model_edge();
    longint prod;
    bit [31:0] dev;
    prod = longint'(m_mod) * longint'(m_gain);
    dev = 32'(prod >>> 15);
    m_dac = dac_of(m_ph);
    m_ph = m_ph + m_ftw + dev;
    if (smp_stb) begin
      m_ftw = m_shf;
      m_gain = m_shg;
      m_mod = m_src ? sine16(m_tph) : int'($signed(smp_in));
    end
    m_tph = m_tph + TONE;
    if (cfg_we)
      case (cfg_sel)
        2'd0: m_shf = cfg_data;
        2'd1: m_shg = cfg_data[23:0];
        2'd2: m_src = cfg_data[0];
        default: ;
      endcase
  endtask

  task automatic check(string r, bit [7:0] exp);
    total++;
    if (dac_code !== exp) begin
      bad++;
      $display("FAIL %s: dac_code=%0d expected=%0d at %0t", r, dac_code, exp, $time);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check(req, m_dac);
    cfg_we = 0;
    smp_stb = 0;
  endtask

  task automatic wr(bit [1:0] s, bit [31:0] d);
    cfg_we = 1; cfg_sel = s; cfg_data = d;
  endtask

  initial begin
    #(CLK_NS * 200000);
    bad++;
    $display("FAIL watchdog: run did not complete, expected finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk); @(negedge clk);
    check("R1", 8'h80);
    rst_n = 1;
    cyc(); check("R1", 8'h80);

    req = "R3";  // carrier only, 10.7 MHz word
    wr(0, 32'h2DA740DA); cyc();
    smp_stb = 1; repeat (300) cyc();

    req = "R5";  // held write must not act without strobe; write on strobe waits
    wr(0, 32'h10000000); repeat (60) cyc();
    wr(0, 32'h01234567); smp_stb = 1; repeat (40) cyc();
    smp_stb = 1; repeat (40) cyc();

    req = "R4";  // external modulation, random samples
    wr(1, 24'd172166); cyc();
    for (int k = 0; k < 3000; k++) begin
      if (k % 4 == 0) begin smp_stb = 1; smp_in = 16'($urandom); end
      if (k == 1500) wr(1, 24'd5370000);
      cyc();
    end

    req = "R4";  // extremes: full negative/positive sample, max gain, wrap
    wr(1, 24'hFFFFFF); smp_stb = 1; smp_in = 16'h8000; cyc();
    smp_stb = 1; repeat (200) cyc();
    smp_stb = 1; smp_in = 16'h7FFF; repeat (200) cyc();
    wr(0, 32'hFFFFFFFF); smp_stb = 1; smp_in = 16'h0000; cyc();
    smp_stb = 1; repeat (100) cyc();

    req = "R6";  // switch to test tone, 10.7 MHz, 2405 Hz gain
    wr(0, 32'h2DA740DA); cyc();
    wr(1, 24'd172166); cyc();
    wr(2, 32'd1); smp_stb = 1; cyc();
    for (int k = 0; k < 4000; k++) begin
      smp_stb = (k % 3 == 0);
      smp_in = 16'($urandom);
      cyc();
    end

    req = "R7";  // tone every clock with larger gain
    wr(1, 24'd2000000); smp_stb = 1; cyc();
    smp_stb = 1; repeat (2000) cyc();

    req = "R8";  // random traffic including ignored select 3
    for (int k = 0; k < 3000; k++) begin
      int r;
      r = int'($urandom % 10);
      if (r < 3) wr(2'd3, $urandom);
      else if (r == 3) wr(2'($urandom % 3), $urandom);
      smp_stb = ($urandom % 5 == 0);
      smp_in = 16'($urandom);
      cyc();
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule